// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers interrupt events from on-chip peripherals into one pending register and sends a single request line to the processor. Each peripheral has its own bit position. When a peripheral raises a one-cycle pulse on its line, the matching pending bit is set and stays set. An enable mask register decides which pending bits may drive the request.

Software reaches both registers over a simple 32-bit register bus with separate read and write strobes. To acknowledge an event, software writes the pending register. The written word is ANDed into the register: a 0 in a bit position clears that bit, and a 1 leaves it as it is. The request output is registered. It follows pending AND enable, so an event that is enabled at the moment it arrives raises the request on the next edge. A mask write that enables a bit which is already pending raises the request on the next edge as well.

By convention, bit 3 carries the DMA controller's event, bit 7 the serial port's and bit 9 the sound unit's. The logic treats every bit the same way.

Top module: `irqc_ctrl`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, the pending register, the enable register and the request output are all zero.
- R2: A one-cycle pulse on a source line sets the pending bit at the same index. The bit stays set until software acknowledges it.
- R3: A write to offset 0x70 replaces the pending register with its old value ANDed with write data bits 15:0. A 0 clears the bit and a 1 keeps it.
- R4: A write to offset 0x74 replaces the whole enable register with write data bits 15:0. The enable register does not change at any other time.
- R5: If a source pulse and an acknowledge write that clears the same bit happen in the same cycle, the bit ends up set.
- R6: The request output is a register. After each clock edge it equals the OR of (pending AND enable), taken from the values the registers load at that edge.
- R7: A write to the enable register that enables a bit which is already pending raises the request on the edge that takes the write.
- R8: A read with the strobe at offset 0x70 or 0x74 returns that register in bits 15:0 on the clock after the strobe, with bits 31:16 zero. A read of any other offset returns zero. A write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | 16 | Event pulses from the peripherals, one bit per source |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid on the clock after a read strobe |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench drives a source pulse into a bit in the same cycle that an acknowledge write clears that bit. A design that gives the write priority would lose the event and read back zero there. It also writes all ones to the pending register, which a write-one-to-clear design would read as an acknowledge of every bit. It writes the enable register while events are already pending; a request computed from the old register values would come a cycle late, or not at all. Finally, it reads and writes an unmapped offset to catch decoders that alias or zero-pad the wrong way.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2
   } irqc_sel_e;
endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
   import irqc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h70,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h74
) (
   input  logic [ADDR_W-1:0] addr,
   output irqc_sel_e         sel
);
   always_comb begin
      if (addr == STAT_OFS)      sel = SEL_STAT;
      else if (addr == MASK_OFS) sel = SEL_MASK;
      else                       sel = SEL_NONE;
   end
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
   parameter int NSRC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic            ack_en,
   input  logic [NSRC-1:0] ack_val,
   output logic [NSRC-1:0] stat_d,
   output logic [NSRC-1:0] stat_q
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      // a new event is ORed in after the AND, so it outlives the acknowledge
      assign stat_d[i] = src[i] | (stat_q[i] & (~ack_en | ack_val[i]));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[i] <= 1'b0;
         else        stat_q[i] <= stat_d[i];
      end
   end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
   parameter int NSRC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [NSRC-1:0] wval,
   output logic [NSRC-1:0] mask_d,
   output logic [NSRC-1:0] mask_q
);
   assign mask_d = wr_en ? wval : mask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
   import irqc_pkg::*;
#(
   parameter int NSRC     = 16,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h70,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h74
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_pulse,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   initial begin
      assert (NSRC >= 1 && NSRC <= DATA_W)
         else $error("irqc_ctrl: NSRC must lie in 1..DATA_W");
      assert (STAT_OFS != MASK_OFS)
         else $error("irqc_ctrl: register offsets must differ");
   end

   irqc_sel_e       sel;
   logic [NSRC-1:0] stat_d, stat_q, mask_d, mask_q;
   logic [DATA_W-1:0] stat_w, mask_w;
   logic            irq_q;

   irqc_regdec #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   irqc_status #(.NSRC(NSRC)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_pulse),
      .ack_en  (bus_wr && sel == SEL_STAT),
      .ack_val (bus_wdata[NSRC-1:0]),
      .stat_d  (stat_d),
      .stat_q  (stat_q)
   );

   irqc_mask #(.NSRC(NSRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr && sel == SEL_MASK),
      .wval   (bus_wdata[NSRC-1:0]),
      .mask_d (mask_d),
      .mask_q (mask_q)
   );

   // request built from next-state values so a mask write acts at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_d & mask_d);
   end
   assign irq = irq_q;

   if (DATA_W > NSRC) begin : g_pad
      assign stat_w = {{(DATA_W-NSRC){1'b0}}, stat_q};
      assign mask_w = {{(DATA_W-NSRC){1'b0}}, mask_q};
   end else begin : g_full
      assign stat_w = stat_q;
      assign mask_w = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) begin
         case (sel)
            SEL_STAT: bus_rdata <= stat_w;
            SEL_MASK: bus_rdata <= mask_w;
            default:  bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/irqc_ctrl_chk.sv
module irqc_ctrl_chk #(
   parameter int NSRC   = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h70,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h74
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   src_pulse,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NSRC-1:0]   stat_q,
   input logic [NSRC-1:0]   mask_q,
   input logic              irq
);
   // R1
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (stat_q == '0 && mask_q == '0 && !irq));
   // R2, R5
   p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_pulse) |=> ((stat_q & $past(src_pulse)) == $past(src_pulse)));
   // R3
   p_and_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_OFS && src_pulse == '0)
      |=> stat_q == ($past(stat_q) & $past(bus_wdata[NSRC-1:0])));
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wr && bus_addr == STAT_OFS) && src_pulse == '0) |=> $stable(stat_q));
   // R4
   p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == MASK_OFS) |=> mask_q == $past(bus_wdata[NSRC-1:0]));
   p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == MASK_OFS) |=> $stable(mask_q));
   // R6, R7
   p_req_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(stat_q & mask_q));
endmodule

bind irqc_ctrl irqc_ctrl_chk #(
   .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_pulse (src_pulse),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .stat_q    (stat_q),
   .mask_q    (mask_q),
   .irq       (irq)
);

// File: tb/irqc_ctrl_tb.sv
`timescale 1ns/1ps
module irqc_ctrl_tb;
   localparam logic [7:0] A_STAT = 8'h70;
   localparam logic [7:0] A_MASK = 8'h74;
   localparam logic [7:0] A_NONE = 8'h78;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_pulse = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic rd_q = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irqc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares read data on the clock after each read strobe
   always @(posedge clk) rd_q <= bus_rd;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) chk("scoreboard-empty", 32'h1, 32'h0);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, logic [15:0] pulse);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; src_pulse = pulse;
      @(negedge clk);
      bus_wr = 1'b0; src_pulse = '0;
   endtask

   task automatic pulse(logic [15:0] p);
      @(negedge clk);
      src_pulse = p;
      @(negedge clk);
      src_pulse = '0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      rd(A_STAT, 32'h0, "R1 status after reset");
      rd(A_MASK, 32'h0, "R1 mask after reset");

      pulse(16'h0088);                       // DMA and serial events
      chk("R6 masked off irq", {31'b0, irq}, 32'h0);
      rd(A_STAT, 32'h0000_0088, "R2 pulses latched");

      wr(A_MASK, 32'hABCD_0200, 16'h0);
      chk("R4 irq with unrelated mask", {31'b0, irq}, 32'h0);
      rd(A_MASK, 32'h0000_0200, "R4 mask readback R8 upper zero");

      pulse(16'h0200);                       // sound event
      chk("R6 irq on enabled event", {31'b0, irq}, 32'h1);
      rd(A_STAT, 32'h0000_0288, "R2 three bits pending");

      wr(A_STAT, 32'hFFFF_FFFF, 16'h0);
      rd(A_STAT, 32'h0000_0288, "R3 all ones keeps bits");
      wr(A_STAT, 32'h0000_FDFF, 16'h0);
      chk("R6 irq drops after ack", {31'b0, irq}, 32'h0);
      rd(A_STAT, 32'h0000_0088, "R3 zero clears bit 9");

      wr(A_MASK, 32'h0000_0008, 16'h0);
      chk("R7 irq on mask write", {31'b0, irq}, 32'h1);

      wr(A_STAT, 32'h0000_0000, 16'h0008);   // pulse beats the acknowledge
      rd(A_STAT, 32'h0000_0008, "R5 pulse wins over ack");
      chk("R5 irq kept", {31'b0, irq}, 32'h1);

      wr(A_STAT, 32'h0000_0000, 16'h0);
      chk("R3 irq after full ack", {31'b0, irq}, 32'h0);
      rd(A_STAT, 32'h0, "R3 status empty");

      pulse(16'h0081);
      wr(A_NONE, 32'h0000_0000, 16'h0);
      wr(A_NONE, 32'hFFFF_FFFF, 16'h0);
      rd(A_NONE, 32'h0, "R8 unmapped read zero");
      rd(A_STAT, 32'h0000_0081, "R8 unmapped write leaves status");
      rd(A_MASK, 32'h0000_0008, "R8 unmapped write leaves mask");

      wr(A_MASK, 32'h0000_FFFF, 16'h0);
      chk("R7 full mask raises irq", {31'b0, irq}, 32'h1);
      pulse(16'h8000);
      rd(A_STAT, 32'h0000_8081, "R2 top bit R8 no spill");

      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 irq cleared by reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      rd(A_STAT, 32'h0, "R1 status cleared by reset");
      rd(A_MASK, 32'h0, "R1 mask cleared by reset");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule